// File: doc/BRIEF.md
# Four-Channel DMA Transfer Controller

This block moves bytes between memory and peripherals on an 8-bit data bus with 16-bit addressing, so that the CPU does not have to touch each byte. It has two roles. While the CPU owns the bus, the block acts as a slave. The CPU selects one of its registers with a 4-bit address, a chip select and read and write strobes. Through these registers the CPU sets each channel's start address, transfer count and transfer kind, and it sets which channels are enabled and how they are prioritised.

When an enabled channel sees its peripheral request, the block raises a hold request toward the CPU. It then waits for hold acknowledge before it takes over the bus. Each transfer has three phases:

- An address phase. The low address byte goes out on the address outputs. The high address byte goes out on the data lines, together with a one-clock strobe that loads an external latch.
- A strobe phase. The memory and I/O strobes that fit the channel's kind are driven here. A low ready input stretches this phase.
- A closing phase. The strobes are released and the channel's address and counter advance.

The serviced channel's acknowledge line is held low through all three phases. Terminal count and a mark pulse every 128 transfers are signalled during the strobe phase. A channel switches itself off once its last transfer is done.

Top module: `dma4_ctrl`

## Requirements
- R1: After synchronous reset, hold request, address enable and the address strobe are low, every acknowledge is high, the data bus is not driven, and all channels are disabled, so that requests raise no hold request.
- R2: Register map. Channel n has its address word at register 2n and its count word at register 2n+1. Bits 15:14 of the count word give the kind (00 verify, 01 write, 10 read), and bits 13:0 give the count. Register 8 is the mode register: bits 3:0 enable channels 0 to 3, and bit 4 selects rotating priority. A word is accessed low byte first, then high byte. A mode write makes the next access a low byte. Reads return the stored values.
- R3: An enabled, requesting channel raises hold request. Address enable stays low until hold acknowledge has been seen high.
- R4: In its strobe phase, a read-kind transfer drives memory read and I/O write low. A write-kind transfer drives I/O read and memory write low. A verify transfer drives no strobe.
- R5: Each transfer starts with a one-clock address strobe. In that cycle the data lines carry address bits 15:8, the address outputs carry bits 7:0, and the data lines are driven.
- R6: Address enable is high for the whole transfer (address, strobe and closing phases), and no memory or I/O strobe is ever low outside it.
- R7: Each transfer increments the channel address by one, carrying across the byte boundary. The incremented value can be read back.
- R8: A loaded count N gives N+1 transfers. Terminal count is high during the strobe phase of the transfer made with count zero. After that transfer the channel's enable bit reads back as 0.
- R9: While ready is low, the strobe phase, its strobes and terminal count are held.
- R10: The acknowledge lines are active low. At most one is low at a time, and the serviced channel's line is low through its transfer.
- R11: With fixed priority, the lowest-numbered pending channel is served first.
- R12: With rotating priority, the channel just served becomes the lowest priority, so the channels that are requesting are served in turn.
- R13: Mark is high during the strobe phase of every 128th transfer counted from reset, over all channels.
- R14: Hold request falls when no enabled channel is requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select for register access, active low |
| rd_n | input | 1 | Register read strobe, active low |
| wr_n | input | 1 | Register write strobe, active low |
| addr_in | input | 4 | Register select |
| data_in | input | 8 | Write data from the host |
| data_out | output | 8 | Read data, or high address byte in the address phase |
| data_oe | output | 1 | Data lines are driven |
| dreq | input | 4 | Peripheral requests, asynchronous |
| dack_n | output | 4 | Per-channel acknowledge, active low |
| hrq | output | 1 | Hold request to the CPU |
| hlda | input | 1 | Hold acknowledge from the CPU |
| ready | input | 1 | Low inserts wait states |
| aen | output | 1 | Block owns the bus |
| adstb | output | 1 | High-address latch strobe |
| addr_out | output | 8 | Low address byte while owning the bus |
| memr_n | output | 1 | Memory read strobe |
| memw_n | output | 1 | Memory write strobe |
| io_rd_n | output | 1 | I/O read strobe |
| io_wr_n | output | 1 | I/O write strobe |
| tc | output | 1 | Terminal count |
| mark | output | 1 | Every-128th-transfer pulse |

## Verification
Terminal count and mark can fall in the same strobe phase. This happens when the 128th transfer since the last mark is also a channel's final transfer. The bench provokes this by resetting, loading a count of 127 into one channel, and letting it run. It then checks that the two pulses were seen high together exactly once. It also checks that a second 128-transfer run marks again, and that a 64-transfer run does not. Wait states that land on a terminal-count transfer are judged by holding ready low and seeing that terminal count, acknowledge and the strobe all stay asserted.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_ADDR,
    ST_XFER,
    ST_DONE
  } dma_state_e;

  typedef enum logic [1:0] {
    XK_VERIFY = 2'b00,
    XK_WRITE  = 2'b01,
    XK_READ   = 2'b10,
    XK_SPARE  = 2'b11
  } xfer_kind_e;
endpackage

// File: rtl/dma4_sync.sv
module dma4_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input  logic [NCH-1:0] pend,
  input  logic           rotate,
  input  logic [CHW-1:0] last,
  output logic [CHW-1:0] pick
);
  int idx;

  always_comb begin
    pick = '0;
    idx  = 0;
    if (rotate) begin
      // walk from the farthest slot down so the nearest one after 'last' wins
      for (int k = NCH; k >= 1; k--) begin
        idx = (int'(last) + k) % NCH;
        if (pend[idx]) pick = CHW'(idx);
      end
    end else begin
      for (int k = NCH - 1; k >= 0; k--) begin
        if (pend[k]) pick = CHW'(k);
      end
    end
  end
endmodule

// File: rtl/dma4_chan.sv
module dma4_chan #(
  parameter int AW = 16,
  parameter int CW = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_addr,
  input  logic            ld_cnt,
  input  logic            hi_byte,
  input  logic [7:0]      wdata,
  input  logic            step,
  output logic [AW-1:0]   addr,
  output logic [CW+1:0]   word
);
  localparam int WW = CW + 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      word <= '0;
    end else begin
      if (ld_addr) begin
        if (hi_byte) addr[AW-1:8] <= wdata[AW-9:0];
        else         addr[7:0]    <= wdata;
      end
      if (ld_cnt) begin
        if (hi_byte) word[WW-1:8] <= wdata[WW-9:0];
        else         word[7:0]    <= wdata;
      end
      if (step) begin
        addr <= addr + AW'(1);
        if (word[CW-1:0] != '0) word[CW-1:0] <= word[CW-1:0] - CW'(1);
      end
    end
  end
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int AW     = 16,
  parameter int CW     = 14,
  parameter int MARK_N = 128
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [3:0]     addr_in,
  input  logic [7:0]     data_in,
  output logic [7:0]     data_out,
  output logic           data_oe,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack_n,
  output logic           hrq,
  input  logic           hlda,
  input  logic           ready,
  output logic           aen,
  output logic           adstb,
  output logic [7:0]     addr_out,
  output logic           memr_n,
  output logic           memw_n,
  output logic           io_rd_n,
  output logic           io_wr_n,
  output logic           tc,
  output logic           mark
);
  localparam int CHW       = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int MW        = $clog2(MARK_N);
  localparam int WW        = CW + 2;
  localparam int MODE_ADDR = 2 * NCH;

  dma_state_e     state_q;
  logic [CHW-1:0] gnt_q, last_q, pick;
  logic [MW-1:0]  mcnt_q;
  logic [NCH-1:0] en_q, req_s, pend;
  logic           rot_q, hi_q;
  logic [AW-1:0]  ch_addr [NCH];
  logic [WW-1:0]  ch_word [NCH];

  logic           bus_own, host_sel, host_wr, host_rd, ch_hit, mode_hit;
  logic [CHW-1:0] reg_ch;
  logic [AW-1:0]  sel_addr;
  logic [WW-1:0]  sel_word;
  logic           sel_last;
  xfer_kind_e     sel_kind;
  logic [7:0]     rd_byte;

  dma4_sync #(.W(NCH)) u_sync (.clk(clk), .rst(rst), .d(dreq), .q(req_s));

  assign pend     = req_s & en_q;
  assign bus_own  = (state_q == ST_ADDR) || (state_q == ST_XFER) || (state_q == ST_DONE);
  assign host_sel = !cs_n && !bus_own;
  assign host_wr  = host_sel && !wr_n;
  assign host_rd  = host_sel && !rd_n && wr_n;
  assign ch_hit   = addr_in < 4'(MODE_ADDR);
  assign mode_hit = addr_in == 4'(MODE_ADDR);
  assign reg_ch   = addr_in[CHW:1];
  assign sel_addr = ch_addr[gnt_q];
  assign sel_word = ch_word[gnt_q];
  assign sel_last = sel_word[CW-1:0] == '0;
  assign sel_kind = xfer_kind_e'(sel_word[WW-1:CW]);

  dma4_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
    .pend(pend), .rotate(rot_q), .last(last_q), .pick(pick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma4_chan #(.AW(AW), .CW(CW)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .ld_addr(host_wr && ch_hit && (reg_ch == CHW'(i)) && !addr_in[0]),
      .ld_cnt (host_wr && ch_hit && (reg_ch == CHW'(i)) && addr_in[0]),
      .hi_byte(hi_q),
      .wdata  (data_in),
      .step   ((state_q == ST_DONE) && (gnt_q == CHW'(i))),
      .addr   (ch_addr[i]),
      .word   (ch_word[i])
    );
  end

  // host side: mode register and byte-order flag
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      rot_q <= 1'b0;
      hi_q  <= 1'b0;
    end else begin
      if (host_wr && mode_hit) begin
        en_q  <= data_in[NCH-1:0];
        rot_q <= data_in[NCH];
        hi_q  <= 1'b0;
      end else if ((host_wr || host_rd) && ch_hit) begin
        hi_q <= !hi_q;
      end
      if ((state_q == ST_DONE) && sel_last) en_q[gnt_q] <= 1'b0;
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    if (mode_hit) begin
      rd_byte = 8'({rot_q, en_q});
    end else if (ch_hit) begin
      if (addr_in[0]) rd_byte = hi_q ? 8'(ch_word[reg_ch] >> 8) : ch_word[reg_ch][7:0];
      else            rd_byte = hi_q ? 8'(ch_addr[reg_ch] >> 8) : ch_addr[reg_ch][7:0];
    end
  end

  // bus-master sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      gnt_q   <= '0;
      last_q  <= CHW'(NCH - 1);
      mcnt_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (|pend) state_q <= ST_HOLD;
        ST_HOLD: begin
          if (!(|pend)) begin
            state_q <= ST_IDLE;
          end else if (hlda) begin
            state_q <= ST_ADDR;
            gnt_q   <= pick;
          end
        end
        ST_ADDR: state_q <= ST_XFER;
        ST_XFER: if (ready) state_q <= ST_DONE;
        ST_DONE: begin
          state_q <= ST_HOLD;
          last_q  <= gnt_q;
          mcnt_q  <= (mcnt_q == MW'(MARK_N - 1)) ? '0 : mcnt_q + MW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    hrq      = state_q != ST_IDLE;
    aen      = bus_own;
    adstb    = state_q == ST_ADDR;
    addr_out = bus_own ? sel_addr[7:0] : 8'h00;
    data_oe  = adstb || host_rd;
    data_out = adstb ? 8'(sel_addr >> 8) : (host_rd ? rd_byte : 8'h00);
    memr_n   = 1'b1;
    memw_n   = 1'b1;
    io_rd_n  = 1'b1;
    io_wr_n  = 1'b1;
    if (state_q == ST_XFER) begin
      case (sel_kind)
        XK_READ:  begin memr_n = 1'b0; io_wr_n = 1'b0; end
        XK_WRITE: begin io_rd_n = 1'b0; memw_n = 1'b0; end
        default:  ;
      endcase
    end
    tc   = (state_q == ST_XFER) && sel_last;
    mark = (state_q == ST_XFER) && (mcnt_q == MW'(MARK_N - 1));
    for (int i = 0; i < NCH; i++) dack_n[i] = !(bus_own && (gnt_q == CHW'(i)));
  end
endmodule

// File: rtl/dma4_chk.sv
module dma4_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           aen,
  input logic           hrq,
  input logic           hlda,
  input logic           adstb,
  input logic           ready,
  input logic           memr_n,
  input logic           memw_n,
  input logic           io_rd_n,
  input logic           io_wr_n,
  input logic           tc,
  input logic [NCH-1:0] dack_n
);
  AST_AEN_AFTER_HLDA: assert property (@(posedge clk) disable iff (rst) $rose(aen) |-> hlda); // R3
  AST_AEN_NEEDS_HRQ: assert property (@(posedge clk) disable iff (rst) aen |-> hrq); // R3
  AST_READ_PAIR: assert property (@(posedge clk) disable iff (rst) !memr_n |-> (!io_wr_n && io_rd_n && memw_n)); // R4
  AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (rst) !memw_n |-> (!io_rd_n && io_wr_n && memr_n)); // R4
  AST_ADSTB_PULSE: assert property (@(posedge clk) disable iff (rst) adstb |=> !adstb); // R5
  AST_ADSTB_OWNED: assert property (@(posedge clk) disable iff (rst) adstb |-> aen); // R6
  AST_STROBE_OWNED: assert property (@(posedge clk) disable iff (rst) (!memr_n || !memw_n || !io_rd_n || !io_wr_n) |-> aen); // R6
  AST_TC_ACKED: assert property (@(posedge clk) disable iff (rst) tc |-> (dack_n != '1)); // R8
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst) (!memr_n && !ready) |=> (!memr_n && $stable(tc))); // R9
  AST_ONE_ACK: assert property (@(posedge clk) disable iff (rst) $onehot0(~dack_n)); // R10
  AST_ACK_OWNED: assert property (@(posedge clk) disable iff (rst) (dack_n != '1) |-> aen); // R10
endmodule

bind dma4_ctrl dma4_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .aen(aen), .hrq(hrq), .hlda(hlda), .adstb(adstb),
  .ready(ready), .memr_n(memr_n), .memw_n(memw_n), .io_rd_n(io_rd_n),
  .io_wr_n(io_wr_n), .tc(tc), .dack_n(dack_n)
);

// File: tb/sim_dma4_ctrl.sv
`timescale 1ns/1ps
module sim_dma4_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0] addr_in = 4'h0;
  logic [7:0] data_in = 8'h00;
  logic [7:0] data_out;
  logic       data_oe;
  logic [3:0] dreq = 4'h0;
  logic [3:0] dack_n;
  logic       hrq, aen, adstb, memr_n, memw_n, io_rd_n, io_wr_n, tc, mark;
  logic       hlda = 1'b0;
  logic       ready = 1'b1;
  logic [7:0] addr_out;
  logic       auto_hlda = 1'b1;

  int nchk = 0, nerr = 0, cyc = 0;

  // monitor state
  int         xfers [4];
  logic [15:0] seen_addr [4];
  int         order [16];
  int         n_order = 0;
  int         tc_rise = 0, mark_rise = 0, both_cnt = 0;
  bit         saw_memr = 0, saw_memw = 0, saw_iord = 0, saw_iowr = 0;
  bit         prev_tc = 0, prev_mark = 0;

  always #4 clk = ~clk;

  dma4_ctrl u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr_in(addr_in), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .dreq(dreq), .dack_n(dack_n), .hrq(hrq), .hlda(hlda), .ready(ready),
    .aen(aen), .adstb(adstb), .addr_out(addr_out), .memr_n(memr_n), .memw_n(memw_n),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .tc(tc), .mark(mark)
  );

  // CPU model: grants the bus one clock after the request
  always @(negedge clk) begin
    if (rst) hlda <= 1'b0;
    else     hlda <= auto_hlda && hrq;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (adstb) begin
        for (int i = 0; i < 4; i++) begin
          if (!dack_n[i]) begin
            xfers[i]++;
            seen_addr[i] = {data_out, addr_out};
            if (n_order < 16) begin
              order[n_order] = i;
              n_order++;
            end
          end
        end
      end
      if (!memr_n)  saw_memr = 1;
      if (!memw_n)  saw_memw = 1;
      if (!io_rd_n) saw_iord = 1;
      if (!io_wr_n) saw_iowr = 1;
      if (tc && !prev_tc) tc_rise++;
      if (mark && !prev_mark) mark_rise++;
      if (tc && mark && !(prev_tc && prev_mark)) both_cnt++;
      prev_tc   = tc;
      prev_mark = mark;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    for (int i = 0; i < 4; i++) begin
      xfers[i] = 0;
      seen_addr[i] = 16'h0;
    end
    n_order = 0;
    tc_rise = 0; mark_rise = 0; both_cnt = 0;
    saw_memr = 0; saw_memw = 0; saw_iord = 0; saw_iowr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr_in = a; data_in = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr_in = a;
    #1;
    d  = data_out;
    oe = data_oe;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic prog_ch(input int ch, input logic [15:0] a, input logic [1:0] kind, input logic [13:0] cnt);
    wr_reg(4'(2 * ch), a[7:0]);
    wr_reg(4'(2 * ch), a[15:8]);
    wr_reg(4'(2 * ch + 1), cnt[7:0]);
    wr_reg(4'(2 * ch + 1), {kind, cnt[13:8]});
  endtask

  task automatic wait_quiet();
    repeat (4) @(negedge clk);
    for (int k = 0; k < 6000 && hrq; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "hrq after reset", hrq, 0);
    chk("R1", "aen after reset", aen, 0);
    chk("R1", "adstb after reset", adstb, 0);
    chk("R1", "dack_n after reset", dack_n, 4'hF);
    chk("R1", "data_oe after reset", data_oe, 0);
    dreq = 4'hF;
    repeat (10) @(negedge clk);
    chk("R1", "hrq with disabled channels", hrq, 0);
    dreq = 4'h0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    logic oe;
    prog_ch(1, 16'h1234, 2'b10, 14'h0ABC);
    rd_reg(4'd2, d, oe); chk("R2", "addr1 low byte", d, 8'h34);
    chk("R2", "data_oe on read", oe, 1);
    rd_reg(4'd2, d, oe); chk("R2", "addr1 high byte", d, 8'h12);
    rd_reg(4'd3, d, oe); chk("R2", "count1 low byte", d, 8'hBC);
    rd_reg(4'd3, d, oe); chk("R2", "count1 high byte", d, 8'h8A);
    wr_reg(4'd8, 8'h10);
    rd_reg(4'd8, d, oe); chk("R2", "mode readback", d, 8'h10);
    wr_reg(4'd8, 8'h00);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    logic oe;
    clear_mon();
    auto_hlda = 1'b0;
    prog_ch(0, 16'h0100, 2'b10, 14'd0);
    wr_reg(4'd8, 8'h01);
    dreq = 4'h1;
    repeat (6) @(negedge clk);
    chk("R3", "hrq raised on request", hrq, 1);
    chk("R3", "aen low before hlda", aen, 0);
    chk("R3", "no ack before hlda", dack_n, 4'hF);
    auto_hlda = 1'b1;
    wait_quiet();
    chk("R5", "one transfer ch0", xfers[0], 1);
    chk("R5", "latched address ch0", seen_addr[0], 16'h0100);
    chk("R4", "read kind memr+iow", int'(saw_memr && saw_iowr), 1);
    chk("R4", "read kind no memw/ior", int'(saw_memw || saw_iord), 0);
    chk("R8", "tc seen once", tc_rise, 1);
    chk("R14", "hrq dropped", hrq, 0);
    rd_reg(4'd8, d, oe);
    chk("R8", "enable cleared after tc", d, 8'h00);
    dreq = 4'h0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_types();
    logic [7:0] lo, hi;
    logic oe;
    clear_mon();
    prog_ch(2, 16'h2FFE, 2'b01, 14'd2);
    wr_reg(4'd8, 8'h04);
    dreq = 4'h4;
    wait_quiet();
    dreq = 4'h0;
    chk("R8", "count 2 gives 3 transfers", xfers[2], 3);
    chk("R7", "last address crosses byte", seen_addr[2], 16'h3000);
    chk("R4", "write kind ior+memw", int'(saw_iord && saw_memw), 1);
    chk("R4", "write kind no memr/iow", int'(saw_memr || saw_iowr), 0);
    rd_reg(4'd4, lo, oe);
    rd_reg(4'd4, hi, oe);
    chk("R7", "address readback after run", {hi, lo}, 16'h3001);
    rd_reg(4'd5, lo, oe);
    rd_reg(4'd5, hi, oe);
    chk("R2", "count word keeps kind", {hi, lo}, 16'h4000);
    clear_mon();
    prog_ch(3, 16'h0500, 2'b00, 14'd1);
    wr_reg(4'd8, 8'h08);
    dreq = 4'h8;
    wait_quiet();
    dreq = 4'h0;
    chk("R4", "verify transfers", xfers[3], 2);
    chk("R4", "verify drives no strobe", int'(saw_memr || saw_memw || saw_iord || saw_iowr), 0);
  endtask

  task automatic t_ready();
    clear_mon();
    prog_ch(1, 16'h0040, 2'b10, 14'd0);
    wr_reg(4'd8, 8'h02);
    ready = 1'b0;
    dreq = 4'h2;
    for (int k = 0; k < 50 && memr_n; k++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R9", "strobe held while not ready", memr_n, 0);
    chk("R9", "tc held while not ready", tc, 1);
    chk("R10", "ack held during wait", dack_n, 4'hD);
    ready = 1'b1;
    wait_quiet();
    dreq = 4'h0;
    chk("R9", "transfer completes after ready", xfers[1], 1);
  endtask

  task automatic t_prio(input bit rot);
    int bad = 0;
    clear_mon();
    for (int c = 0; c < 4; c++) prog_ch(c, 16'(c * 16'h1000), 2'b00, 14'd1);
    wr_reg(4'd8, rot ? 8'h1F : 8'h0F);
    dreq = 4'hF;
    wait_quiet();
    dreq = 4'h0;
    for (int k = 0; k < 8; k++) begin
      if (order[k] != (rot ? (k % 4) : (k / 2))) bad++;
    end
    if (rot) begin
      chk("R12", "rotating transfer count", n_order, 8);
      chk("R12", "rotating order mismatches", bad, 0);
    end else begin
      chk("R11", "fixed transfer count", n_order, 8);
      chk("R11", "fixed order mismatches", bad, 0);
    end
  endtask

  task automatic t_mark_tc();
    do_reset();
    clear_mon();
    prog_ch(0, 16'h8000, 2'b00, 14'd127);
    wr_reg(4'd8, 8'h01);
    dreq = 4'h1;
    wait_quiet();
    dreq = 4'h0;
    chk("R8", "count 127 gives 128 transfers", xfers[0], 128);
    chk("R13", "one mark in 128", mark_rise, 1);
    chk("R8", "one tc", tc_rise, 1);
    chk("R13", "tc and mark together", both_cnt, 1);
    clear_mon();
    prog_ch(1, 16'h9000, 2'b00, 14'd127);
    wr_reg(4'd8, 8'h02);
    dreq = 4'h2;
    wait_quiet();
    dreq = 4'h0;
    chk("R13", "mark again after next 128", mark_rise, 1);
    chk("R13", "second coincidence", both_cnt, 1);
    clear_mon();
    prog_ch(1, 16'h9000, 2'b00, 14'd63);
    wr_reg(4'd8, 8'h02);
    dreq = 4'h2;
    wait_quiet();
    dreq = 4'h0;
    chk("R13", "no mark in 64 transfers", mark_rise, 0);
    chk("R8", "64 transfers done", xfers[1], 64);
  endtask

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_hold();
    t_types();
    t_ready();
    t_prio(1'b0);
    t_prio(1'b1);
    t_mark_tc();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule